// File: doc/BRIEF.md
# Transmit/Receive DMA Command Controller

This block sits between a host command register and a DMA engine. The host writes a 32-bit command word. The block decodes that word into per-queue run state for two transmit priority queues (queue 0 = high, queue 1 = low) and one receive channel. It then tells the engine which queues may proceed. A start request asks the engine to fetch the first descriptor of the queue. A stop request is graceful: the queue keeps moving until the engine reports the end of the current frame. An abort is immediate: every queue it covers drops to idle at once and no completion event is raised. The abort bit stays visible until the engine reports that it is idle, so the host can poll for completion.

Each transmit queue is a state machine with three states. In `TXQ_IDLE` the queue is not running. In `TXQ_RUN` the queue is running with no stop pending. In `TXQ_STOPPING` the queue is running and a stop is pending. The transitions are:

- *start*: `TXQ_IDLE`→`TXQ_RUN`, with a first-fetch pulse.
- *stop*: `TXQ_RUN`→`TXQ_STOPPING`.
- *restart*: `TXQ_STOPPING`→`TXQ_RUN`, with no fetch.
- *frame-end stop*: `TXQ_STOPPING`→`TXQ_IDLE`, with an end event.
- *chain end*: `TXQ_RUN` or `TXQ_STOPPING`→`TXQ_IDLE`, with an end event.
- *abort*: any state→`TXQ_IDLE`, with no event.

Each abort tracker has two states. In `AB_IDLE` no abort is pending. In `AB_WAIT` an abort is pending. The tracker moves *request* `AB_IDLE`→`AB_WAIT`, and *release* `AB_WAIT`→`AB_IDLE` when the engine reports idle. The receive channel has the states `RX_OFF` and `RX_ON`. It moves *enable* `RX_OFF`→`RX_ON`, with a first-fetch pulse, and *abort* `RX_ON`→`RX_OFF`.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: After reset, every output is 0.
- R2: Writing 1 at bit 23 (queue 0) or bit 24 (queue 1) starts an idle queue. After the write edge, `tx_running`, `tx_go` and status bit 23 or 24 read 1, and `tx_fetch_first` pulses for exactly one cycle for that queue only.
- R3: Zero bits in a command word have no effect. A write of all zeros, or a stop written to an idle queue, leaves every output unchanged and raises no end event.
- R4: Writing 1 at bit 16 (queue 0) or bit 17 (queue 1) to a running queue clears its start bit and sets its stop-pending bit. `tx_go` stays 1 until the frame ends. When start and stop are written together, the stop wins: an idle queue stays idle and does not fetch.
- R5: A frame end on a stopping queue moves it to idle. `tx_go` drops, and `irq_tx_end` pulses for one cycle for that queue.
- R6: A chain end on a running or stopping queue moves it to idle and pulses `irq_tx_end` for that queue.
- R7: A start written to a stopping queue cancels the stop. The queue runs again with no fetch pulse and no end event.
- R8: A frame end on a running queue that has no stop pending has no effect.
- R9: Writing 1 at bit 31 sends both transmit queues to idle at the next edge with no end event. Status bit 31 and `tx_abort_req` stay 1 until the edge after `eng_tx_idle` is seen high, then clear.
- R10: A transmit abort takes precedence over start or stop bits in the same write. Starts written while the abort is pending are ignored.
- R11: Writing 1 at bit 7 enables receive. `rx_enabled` and status bit 7 read 1, and `rx_fetch_first` pulses once, only on the off-to-on change. Writing 0 at bit 7 does not disable receive.
- R12: Writing 1 at bit 15 clears receive enable at once. Status bit 15 and `rx_abort_req` stay 1 until `eng_rx_idle` is seen, and enables written in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| eng_frame_end | input | 2 | Per-queue frame-end pulse from the engine |
| eng_chain_end | input | 2 | Per-queue end-of-chain pulse from the engine |
| eng_tx_idle | input | 1 | Transmit engine is idle |
| eng_rx_idle | input | 1 | Receive engine is idle |
| tx_go | output | 2 | Queue may proceed |
| tx_fetch_first | output | 2 | Fetch first descriptor (one-cycle pulse) |
| tx_running | output | 2 | Queue running status |
| tx_abort_req | output | 1 | Transmit abort in progress |
| rx_go | output | 1 | Receive may proceed |
| rx_fetch_first | output | 1 | Fetch first receive descriptor (pulse) |
| rx_enabled | output | 1 | Receive enabled status |
| rx_abort_req | output | 1 | Receive abort in progress |
| irq_tx_end | output | 2 | End-of-queue event (one-cycle pulse) |
| cmd_status | output | 32 | Command word readback, same bit positions |

## Verification
The bench drives a graceful stop and checks that the queue keeps its go signal until the frame end. A design that halted at once would truncate a frame. It drives a start over a pending stop, where a wrong design would either refetch the first descriptor or emit a spurious end event. It holds the engine busy during both kinds of abort. A design that cleared the abort bit early, raised an end event on abort, or let a start written in the same word or during the wait slip through is caught at the status and go outputs. Zero-valued writes and a stop to an idle queue are checked for silent behaviour.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
    // Command word bit positions; the host encodes these.
    localparam int CMD_W          = 32;
    localparam int NQ             = 2;
    localparam int RX_EN_BIT      = 7;
    localparam int RX_ABORT_BIT   = 15;
    localparam int STOP_BASE_BIT  = 16;
    localparam int START_BASE_BIT = 23;
    localparam int TX_ABORT_BIT   = 31;

    typedef enum logic [1:0] {
        TXQ_IDLE     = 2'd0,
        TXQ_RUN      = 2'd1,
        TXQ_STOPPING = 2'd2
    } txq_state_e;

    typedef enum logic {
        AB_IDLE = 1'b0,
        AB_WAIT = 1'b1
    } abort_state_e;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/dma_txq_fsm.sv
module dma_txq_fsm
    import dma_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic abort_i,
    input  logic frame_end_i,
    input  logic chain_end_i,
    output logic run_o,
    output logic stopping_o,
    output logic go_o,
    output logic fetch_o,
    output logic irq_o
);
    txq_state_e st_q, st_d;
    logic       fetch_d, irq_d;

    // Next-state logic; abort overrides everything.
    always_comb begin
        st_d    = st_q;
        fetch_d = 1'b0;
        irq_d   = 1'b0;
        if (abort_i) begin
            st_d = TXQ_IDLE;
        end else begin
            unique case (st_q)
                TXQ_IDLE: begin
                    if (start_i && !stop_i) begin
                        st_d    = TXQ_RUN;
                        fetch_d = 1'b1;
                    end
                end
                TXQ_RUN: begin
                    if (chain_end_i) begin
                        st_d  = TXQ_IDLE;
                        irq_d = 1'b1;
                    end else if (stop_i) begin
                        st_d = TXQ_STOPPING;
                    end
                end
                TXQ_STOPPING: begin
                    if (frame_end_i || chain_end_i) begin
                        st_d  = TXQ_IDLE;
                        irq_d = 1'b1;
                    end else if (start_i && !stop_i) begin
                        st_d = TXQ_RUN;
                    end
                end
                default: st_d = TXQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TXQ_IDLE;
        else        st_q <= st_d;
    end

    // Registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            fetch_o <= fetch_d;
            irq_o   <= irq_d;
        end
    end

    assign run_o      = (st_q == TXQ_RUN);
    assign stopping_o = (st_q == TXQ_STOPPING);
    assign go_o       = (st_q != TXQ_IDLE) && !abort_i;

    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (st_q == TXQ_IDLE) && !irq_o);
    assert_irq_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q == TXQ_IDLE));
    assert_fetch_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (st_q == TXQ_RUN) && ($past(st_q) == TXQ_IDLE));
    assert_stop_waits_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TXQ_STOPPING && !frame_end_i && !chain_end_i && !abort_i && !start_i)
        |=> (st_q == TXQ_STOPPING));
endmodule

// File: rtl/dma_abort_trk.sv
module dma_abort_trk
    import dma_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic idle_i,
    output logic pend_o
);
    abort_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AB_IDLE: if (req_i) st_d = AB_WAIT;
            AB_WAIT: if (idle_i && !req_i) st_d = AB_IDLE;
            default: st_d = AB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= AB_IDLE;
        else        st_q <= st_d;
    end

    assign pend_o = (st_q == AB_WAIT);

    assert_abort_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !idle_i) |=> pend_o);
    assert_abort_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && idle_i && !req_i) |=> !pend_o);
endmodule

// File: rtl/dma_rx_ctl.sv
module dma_rx_ctl
    import dma_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic abort_i,
    output logic en_o,
    output logic fetch_o
);
    rx_state_e st_q, st_d;
    logic      fetch_d;

    always_comb begin
        st_d    = st_q;
        fetch_d = 1'b0;
        unique case (st_q)
            RX_OFF: begin
                if (enable_i && !abort_i) begin
                    st_d    = RX_ON;
                    fetch_d = 1'b1;
                end
            end
            RX_ON: if (abort_i) st_d = RX_OFF;
            default: st_d = RX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fetch_o <= 1'b0;
        else        fetch_o <= fetch_d;
    end

    assign en_o = (st_q == RX_ON);

    assert_rx_abort_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !en_o && !fetch_o);
endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
    import dma_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic [NQ-1:0]    eng_frame_end,
    input  logic [NQ-1:0]    eng_chain_end,
    input  logic             eng_tx_idle,
    input  logic             eng_rx_idle,
    output logic [NQ-1:0]    tx_go,
    output logic [NQ-1:0]    tx_fetch_first,
    output logic [NQ-1:0]    tx_running,
    output logic             tx_abort_req,
    output logic             rx_go,
    output logic             rx_fetch_first,
    output logic             rx_enabled,
    output logic             rx_abort_req,
    output logic [NQ-1:0]    irq_tx_end,
    output logic [CMD_W-1:0] cmd_status
);
    logic          tx_abort_wr, rx_abort_wr, rx_en_wr;
    logic          tx_abort_any, rx_abort_any;
    logic [NQ-1:0] start_wr, stop_wr, stopping;
    logic          unused_data;

    assign tx_abort_wr  = cmd_wr && cmd_data[TX_ABORT_BIT];
    assign rx_abort_wr  = cmd_wr && cmd_data[RX_ABORT_BIT];
    assign rx_en_wr     = cmd_wr && cmd_data[RX_EN_BIT];
    assign tx_abort_any = tx_abort_wr || tx_abort_req;
    assign rx_abort_any = rx_abort_wr || rx_abort_req;
    assign unused_data  = ^cmd_data;

    dma_abort_trk u_tx_abort (
        .clk(clk), .rst_n(rst_n), .req_i(tx_abort_wr),
        .idle_i(eng_tx_idle), .pend_o(tx_abort_req)
    );

    dma_abort_trk u_rx_abort (
        .clk(clk), .rst_n(rst_n), .req_i(rx_abort_wr),
        .idle_i(eng_rx_idle), .pend_o(rx_abort_req)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_txq
        assign start_wr[q] = cmd_wr && cmd_data[START_BASE_BIT + q];
        assign stop_wr[q]  = cmd_wr && cmd_data[STOP_BASE_BIT + q];

        dma_txq_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .start_i(start_wr[q]), .stop_i(stop_wr[q]), .abort_i(tx_abort_any),
            .frame_end_i(eng_frame_end[q]), .chain_end_i(eng_chain_end[q]),
            .run_o(tx_running[q]), .stopping_o(stopping[q]), .go_o(tx_go[q]),
            .fetch_o(tx_fetch_first[q]), .irq_o(irq_tx_end[q])
        );
    end

    dma_rx_ctl u_rx (
        .clk(clk), .rst_n(rst_n), .enable_i(rx_en_wr), .abort_i(rx_abort_any),
        .en_o(rx_enabled), .fetch_o(rx_fetch_first)
    );

    assign rx_go = rx_enabled && !rx_abort_req;

    // Readback at the same bit positions as the command word
    always_comb begin
        cmd_status               = '0;
        cmd_status[RX_EN_BIT]    = rx_enabled;
        cmd_status[RX_ABORT_BIT] = rx_abort_req;
        cmd_status[TX_ABORT_BIT] = tx_abort_req;
        for (int q = 0; q < NQ; q++) begin
            cmd_status[START_BASE_BIT + q] = tx_running[q];
            cmd_status[STOP_BASE_BIT + q]  = stopping[q];
        end
    end

    assert_abort_same_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort_wr |=> (tx_running == '0) && (tx_fetch_first == '0));
endmodule

// File: tb/dma_cmd_ctrl_bench.sv
module dma_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [1:0]  eng_frame_end = '0, eng_chain_end = '0;
    logic        eng_tx_idle = 1'b0, eng_rx_idle = 1'b0;
    logic [1:0]  tx_go, tx_fetch_first, tx_running, irq_tx_end;
    logic        tx_abort_req, rx_go, rx_fetch_first, rx_enabled, rx_abort_req;
    logic [31:0] cmd_status;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dma_cmd_ctrl u_dma_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .eng_frame_end(eng_frame_end), .eng_chain_end(eng_chain_end),
        .eng_tx_idle(eng_tx_idle), .eng_rx_idle(eng_rx_idle),
        .tx_go(tx_go), .tx_fetch_first(tx_fetch_first), .tx_running(tx_running),
        .tx_abort_req(tx_abort_req), .rx_go(rx_go), .rx_fetch_first(rx_fetch_first),
        .rx_enabled(rx_enabled), .rx_abort_req(rx_abort_req),
        .irq_tx_end(irq_tx_end), .cmd_status(cmd_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command write; returns just after the edge that took it.
    task automatic wr(input logic [31:0] d);
        @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
        @(negedge clk); cmd_wr = 1'b0; cmd_data = '0;
    endtask

    task automatic pulse_fe(input logic [1:0] v);
        @(negedge clk); eng_frame_end = v;
        @(negedge clk); eng_frame_end = '0;
    endtask

    task automatic pulse_ce(input logic [1:0] v);
        @(negedge clk); eng_chain_end = v;
        @(negedge clk); eng_chain_end = '0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", cmd_status, 32'h0);
        chk("R1 go", {tx_go, rx_go}, 3'b000);
        chk("R1 pulses", {tx_fetch_first, rx_fetch_first, irq_tx_end}, 5'b0);
        chk("R1 aborts", {tx_abort_req, rx_abort_req, rx_enabled}, 3'b0);
    endtask

    task automatic t_start_high();
        wr(32'h0080_0000);
        chk("R2 running", tx_running, 2'b01);
        chk("R2 go", tx_go, 2'b01);
        chk("R2 fetch", tx_fetch_first, 2'b01);
        chk("R2 status", cmd_status, 32'h0080_0000);
        idle_cycle();
        chk("R2 fetch one cycle", tx_fetch_first, 2'b00);
    endtask

    task automatic t_zero_write();
        wr(32'h0);
        chk("R3 zero write", cmd_status, 32'h0080_0000);
        wr(32'h0002_0000);
        chk("R3 stop idle queue", cmd_status, 32'h0080_0000);
        chk("R3 no irq", irq_tx_end, 2'b00);
        chk("R3 go kept", tx_go, 2'b01);
    endtask

    task automatic t_graceful_stop();
        wr(32'h0001_0000);
        chk("R4 stop pending", cmd_status, 32'h0001_0000);
        chk("R4 go until frame end", tx_go, 2'b01);
        idle_cycle();
        chk("R4 still going", tx_go, 2'b01);
        pulse_fe(2'b01);
        chk("R5 idle", cmd_status, 32'h0);
        chk("R5 go dropped", tx_go, 2'b00);
        chk("R5 irq", irq_tx_end, 2'b01);
        idle_cycle();
        chk("R5 irq one cycle", irq_tx_end, 2'b00);
    endtask

    task automatic t_frame_end_running();
        wr(32'h0100_0000);
        chk("R2 low start fetch", tx_fetch_first, 2'b10);
        pulse_fe(2'b10);
        chk("R8 still running", tx_running, 2'b10);
        chk("R8 no irq", irq_tx_end, 2'b00);
    endtask

    task automatic t_chain_end();
        pulse_ce(2'b10);
        chk("R6 idle", tx_running, 2'b00);
        chk("R6 irq", irq_tx_end, 2'b10);
        wr(32'h0080_0000);
        wr(32'h0001_0000);
        pulse_ce(2'b01);
        chk("R6 from stopping", cmd_status, 32'h0);
        chk("R6 irq stopping", irq_tx_end, 2'b01);
    endtask

    task automatic t_restart();
        wr(32'h0080_0000);
        wr(32'h0001_0000);
        wr(32'h0080_0000);
        chk("R7 running again", cmd_status, 32'h0080_0000);
        chk("R7 no refetch", tx_fetch_first, 2'b00);
        chk("R7 no irq", irq_tx_end, 2'b00);
        wr(32'h0102_0000);
        chk("R4 stop wins idle", tx_running, 2'b01);
        chk("R4 no fetch", tx_fetch_first, 2'b00);
    endtask

    task automatic t_tx_abort();
        wr(32'h0100_0000);
        chk("R9 both running", tx_running, 2'b11);
        eng_tx_idle = 1'b0;
        wr(32'h8000_0000);
        chk("R9 queues idle", tx_running, 2'b00);
        chk("R9 go off", tx_go, 2'b00);
        chk("R9 no irq", irq_tx_end, 2'b00);
        chk("R9 abort bit", cmd_status, 32'h8000_0000);
        repeat (3) idle_cycle();
        chk("R9 abort held", tx_abort_req, 1'b1);
        wr(32'h0080_0000);
        chk("R10 start ignored", tx_running, 2'b00);
        @(negedge clk); eng_tx_idle = 1'b1;
        @(negedge clk);
        chk("R9 abort released", tx_abort_req, 1'b0);
        wr(32'h8080_0000);
        chk("R10 same write", tx_running, 2'b00);
        chk("R10 no fetch", tx_fetch_first, 2'b00);
        idle_cycle();
        chk("R10 released", cmd_status, 32'h0);
        eng_tx_idle = 1'b0;
    endtask

    task automatic t_rx();
        wr(32'h0000_0080);
        chk("R11 enabled", cmd_status, 32'h0000_0080);
        chk("R11 fetch", rx_fetch_first, 1'b1);
        chk("R11 go", rx_go, 1'b1);
        wr(32'h0);
        chk("R11 zero keeps", rx_enabled, 1'b1);
        wr(32'h0000_0080);
        chk("R11 no second fetch", rx_fetch_first, 1'b0);
        eng_rx_idle = 1'b0;
        wr(32'h0000_8000);
        chk("R12 cleared", cmd_status, 32'h0000_8000);
        chk("R12 go off", rx_go, 1'b0);
        wr(32'h0000_0080);
        chk("R12 enable ignored", rx_enabled, 1'b0);
        chk("R12 held", rx_abort_req, 1'b1);
        @(negedge clk); eng_rx_idle = 1'b1;
        @(negedge clk);
        chk("R12 released", cmd_status, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start_high();
        t_zero_write();
        t_graceful_stop();
        t_frame_end_running();
        t_chain_end();
        t_restart();
        t_tx_abort();
        t_rx();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule